// File: doc/BRIEF.md
# Multiplexed-Bus Address Latch and Space Decoder

This block sits between a processor with a multiplexed address/data bus and three bus targets: a 32 KB static RAM, a UART with two registers, and an 8-bit switch-readback port. At the start of each machine cycle the processor drives the low address byte on the shared bus while the address-strobe input is high. The block holds that byte so the rest of the cycle can use the bus for data. From the held byte, the top address bit and the memory/IO cycle flag, it works out which target the cycle addresses and drives that target's select.

It also forms the RAM read and write strobes and the UART enable and direction. A second bus master can take over two paths. It can block RAM reads so that it can place its own byte on the data bus, and it can pulse the RAM write strobe itself. It can also force the switch-port select low through an external chip-select input.

Decoding is deliberately partial. The UART looks only at two low address bits. The switch port looks at one bit. As a result both peripherals answer at many aliased IO addresses.

The decoder classifies each cycle into one of four named targets: `TGT_NONE`, `TGT_RAM`, `TGT_UART` and `TGT_SW`. There are no transitions between them; the class follows the cycle flag and the address directly. The only stored state is the address-latch register. It loads from the bus on every clock edge where the address strobe is high, and it holds otherwise.

Top module: `bus_glue85`

## Requirements
- R1: While `ale_i` is high, `addr_lo_o` equals `ad_i` (the latch is transparent).
- R2: After `ale_i` falls, `addr_lo_o` holds the `ad_i` value sampled at the last rising clock edge with `ale_i` high, whatever `ad_i` does next. Reset with `ale_i` low clears it to 0.
- R3: `ram_oe_n_o` is 0 exactly when `rd_n_i` is 0 and `ram_rd_dis_i` is 0.
- R4: `ram_we_n_o` is 0 exactly when `wr_n_i` is 0 or `ext_wr_n_i` is 0.
- R5: `ram_ce_n_o` is 0 exactly when `io_m_i` is 0 (memory cycle) and `a15_i` is 0.
- R6: `uart_cs_n_o` is 0 exactly when `io_m_i` is 1, bit 7 of `addr_lo_o` is 0 and bit 4 is 1. `uart_rs_o` equals bit 0 of `addr_lo_o`.
- R7: `uart_e_o` is 1 exactly when `rd_n_i` or `wr_n_i` is 0. `uart_rw_o` equals `s1_i`, where 1 means read.
- R8: `sw_cs_n_o` is 0 exactly when (`io_m_i` is 1 and bit 7 of `addr_lo_o` is 1) or `ext_cs_n_i` is 0.
- R9: With `ext_cs_n_i` high, at most one of `ram_ce_n_o`, `uart_cs_n_o` and `sw_cs_n_o` is low. Memory cycles never select the UART or the switch port, and IO cycles never enable the RAM.
- R10: With `rd_n_i`, `wr_n_i` and `ext_wr_n_i` all high, `ram_oe_n_o` and `ram_we_n_o` are high and `uart_e_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the address-latch register |
| rst_n | input | 1 | Active-low reset |
| ad_i | input | 8 | Multiplexed low address / data bus |
| a15_i | input | 1 | Top address bit |
| ale_i | input | 1 | Address strobe, high during the address phase |
| rd_n_i | input | 1 | Processor read strobe, active low |
| wr_n_i | input | 1 | Processor write strobe, active low |
| io_m_i | input | 1 | Cycle type: 1 for IO, 0 for memory |
| s1_i | input | 1 | Early direction status, 1 for read |
| ram_rd_dis_i | input | 1 | Second master blocks RAM reads when high |
| ext_wr_n_i | input | 1 | Second master RAM write strobe, active low |
| ext_cs_n_i | input | 1 | Second master force of the switch-port select, active low |
| addr_lo_o | output | 8 | Latched low address byte |
| ram_ce_n_o | output | 1 | RAM chip enable, active low |
| ram_oe_n_o | output | 1 | RAM read strobe, active low |
| ram_we_n_o | output | 1 | RAM write strobe, active low |
| uart_cs_n_o | output | 1 | UART select, active low |
| uart_rs_o | output | 1 | UART register select |
| uart_e_o | output | 1 | UART enable strobe, active high |
| uart_rw_o | output | 1 | UART direction, 1 for read |
| sw_cs_n_o | output | 1 | Switch-port select, active low |

## Verification
The bench latches every one of the 256 low address bytes. After each one it changes the bus to a different data value, to show that the decoders use the held byte and not the live bus. A decoder wired to the live bus would fail here.

For each address the bench then sweeps the cycle type, the top address bit, every strobe combination and every override input. Four kinds of mistake are caught this way:
- a wrong address bit in the partial decode would create or lose UART and switch aliases;
- a read-disable that gated the write path would miss RAM writes;
- a forced switch select that stayed tied to IO cycles would ignore the second master;
- a decode that did not check the cycle type would turn on two selects at once.

// File: rtl/bus_glue85_pkg.sv
package bus_glue85_pkg;
    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_RAM  = 2'd1,
        TGT_UART = 2'd2,
        TGT_SW   = 2'd3
    } target_e;
endpackage

// File: rtl/bus_glue85_latch.sv
module bus_glue85_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ale,
    input  logic [W-1:0] bus,
    output logic [W-1:0] addr
);
    logic [W-1:0] held_q;

    // The strobe takes priority so a capture during reset is never lost.
    always_ff @(posedge clk) begin
        if (ale)
            held_q <= bus;
        else if (!rst_n)
            held_q <= '0;
    end

    // Transparent while the strobe is high, held otherwise.
    assign addr = ale ? bus : held_q;
endmodule

// File: rtl/bus_glue85_decode.sv
module bus_glue85_decode
    import bus_glue85_pkg::*;
(
    input  logic    io_cyc,
    input  logic    top_bit,
    input  logic    io_hi_bit,
    input  logic    uart_bit,
    output target_e tgt
);
    always_comb begin
        tgt = TGT_NONE;
        if (!io_cyc) begin
            if (!top_bit)
                tgt = TGT_RAM;
        end else if (io_hi_bit) begin
            tgt = TGT_SW;
        end else if (uart_bit) begin
            tgt = TGT_UART;
        end
    end
endmodule

// File: rtl/bus_glue85_strobe.sv
module bus_glue85_strobe
    import bus_glue85_pkg::*;
(
    input  target_e tgt,
    input  logic    rd_n,
    input  logic    wr_n,
    input  logic    rd_block,
    input  logic    ext_wr_n,
    input  logic    ext_cs_n,
    input  logic    early_rd,
    input  logic    reg_bit,
    output logic    ram_ce_n,
    output logic    ram_oe_n,
    output logic    ram_we_n,
    output logic    uart_cs_n,
    output logic    uart_rs,
    output logic    uart_e,
    output logic    uart_rw,
    output logic    sw_cs_n
);
    logic sel_ram, sel_uart, sel_sw;

    always_comb begin
        sel_ram  = 1'b0;
        sel_uart = 1'b0;
        sel_sw   = 1'b0;
        unique case (tgt)
            TGT_NONE: ;
            TGT_RAM:  sel_ram  = 1'b1;
            TGT_UART: sel_uart = 1'b1;
            TGT_SW:   sel_sw   = 1'b1;
        endcase
    end

    assign ram_ce_n  = ~sel_ram;
    assign ram_oe_n  = rd_n | rd_block;
    assign ram_we_n  = wr_n & ext_wr_n;
    assign uart_cs_n = ~sel_uart;
    assign uart_rs   = reg_bit;
    assign uart_e    = ~(rd_n & wr_n);
    assign uart_rw   = early_rd;
    assign sw_cs_n   = ~(sel_sw | ~ext_cs_n);
endmodule

// File: rtl/bus_glue85.sv
module bus_glue85
    import bus_glue85_pkg::*;
#(
    parameter int LO_W      = 8,
    parameter int IO_HI_POS = 7,
    parameter int UART_POS  = 4,
    parameter int RS_POS    = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [LO_W-1:0] ad_i,
    input  logic            a15_i,
    input  logic            ale_i,
    input  logic            rd_n_i,
    input  logic            wr_n_i,
    input  logic            io_m_i,
    input  logic            s1_i,
    input  logic            ram_rd_dis_i,
    input  logic            ext_wr_n_i,
    input  logic            ext_cs_n_i,
    output logic [LO_W-1:0] addr_lo_o,
    output logic            ram_ce_n_o,
    output logic            ram_oe_n_o,
    output logic            ram_we_n_o,
    output logic            uart_cs_n_o,
    output logic            uart_rs_o,
    output logic            uart_e_o,
    output logic            uart_rw_o,
    output logic            sw_cs_n_o
);
    target_e tgt;

    bus_glue85_latch #(.W(LO_W)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .ale   (ale_i),
        .bus   (ad_i),
        .addr  (addr_lo_o)
    );

    bus_glue85_decode u_decode (
        .io_cyc    (io_m_i),
        .top_bit   (a15_i),
        .io_hi_bit (addr_lo_o[IO_HI_POS]),
        .uart_bit  (addr_lo_o[UART_POS]),
        .tgt       (tgt)
    );

    bus_glue85_strobe u_strobe (
        .tgt       (tgt),
        .rd_n      (rd_n_i),
        .wr_n      (wr_n_i),
        .rd_block  (ram_rd_dis_i),
        .ext_wr_n  (ext_wr_n_i),
        .ext_cs_n  (ext_cs_n_i),
        .early_rd  (s1_i),
        .reg_bit   (addr_lo_o[RS_POS]),
        .ram_ce_n  (ram_ce_n_o),
        .ram_oe_n  (ram_oe_n_o),
        .ram_we_n  (ram_we_n_o),
        .uart_cs_n (uart_cs_n_o),
        .uart_rs   (uart_rs_o),
        .uart_e    (uart_e_o),
        .uart_rw   (uart_rw_o),
        .sw_cs_n   (sw_cs_n_o)
    );
endmodule

// File: rtl/bus_glue85_chk.sv
module bus_glue85_chk #(
    parameter int LO_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [LO_W-1:0] ad_i,
    input logic            ale_i,
    input logic            rd_n_i,
    input logic            wr_n_i,
    input logic            io_m_i,
    input logic            ext_wr_n_i,
    input logic            ext_cs_n_i,
    input logic [LO_W-1:0] addr_lo_o,
    input logic            ram_ce_n_o,
    input logic            ram_oe_n_o,
    input logic            ram_we_n_o,
    input logic            uart_cs_n_o,
    input logic            uart_e_o,
    input logic            sw_cs_n_o
);
    // R2
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ale_i && $past(!ale_i)) |-> $stable(addr_lo_o));

    // R2
    latch_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ale_i && $past(ale_i)) |-> (addr_lo_o == $past(ad_i)));

    // R9
    one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_cs_n_i |-> ($countones({~ram_ce_n_o, ~uart_cs_n_o, ~sw_cs_n_o}) <= 1));

    // R9
    mem_no_io_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!io_m_i && ext_cs_n_i) |-> (uart_cs_n_o && sw_cs_n_o));

    // R9
    io_no_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_m_i |-> ram_ce_n_o);

    // R10
    idle_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_n_i && wr_n_i && ext_wr_n_i) |-> (ram_oe_n_o && ram_we_n_o && !uart_e_o));
endmodule

bind bus_glue85 bus_glue85_chk #(.LO_W(LO_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ad_i        (ad_i),
    .ale_i       (ale_i),
    .rd_n_i      (rd_n_i),
    .wr_n_i      (wr_n_i),
    .io_m_i      (io_m_i),
    .ext_wr_n_i  (ext_wr_n_i),
    .ext_cs_n_i  (ext_cs_n_i),
    .addr_lo_o   (addr_lo_o),
    .ram_ce_n_o  (ram_ce_n_o),
    .ram_oe_n_o  (ram_oe_n_o),
    .ram_we_n_o  (ram_we_n_o),
    .uart_cs_n_o (uart_cs_n_o),
    .uart_e_o    (uart_e_o),
    .sw_cs_n_o   (sw_cs_n_o)
);

// File: tb/bus_glue85_tb.sv
module bus_glue85_tb;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] ad_i = 8'h00;
    logic       a15_i = 1'b0, ale_i = 1'b0, rd_n_i = 1'b1, wr_n_i = 1'b1;
    logic       io_m_i = 1'b0, s1_i = 1'b0, ram_rd_dis_i = 1'b0;
    logic       ext_wr_n_i = 1'b1, ext_cs_n_i = 1'b1;
    logic [7:0] addr_lo_o;
    logic       ram_ce_n_o, ram_oe_n_o, ram_we_n_o, uart_cs_n_o;
    logic       uart_rs_o, uart_e_o, uart_rw_o, sw_cs_n_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    bus_glue85 u_dut (
        .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .a15_i(a15_i), .ale_i(ale_i),
        .rd_n_i(rd_n_i), .wr_n_i(wr_n_i), .io_m_i(io_m_i), .s1_i(s1_i),
        .ram_rd_dis_i(ram_rd_dis_i), .ext_wr_n_i(ext_wr_n_i), .ext_cs_n_i(ext_cs_n_i),
        .addr_lo_o(addr_lo_o), .ram_ce_n_o(ram_ce_n_o), .ram_oe_n_o(ram_oe_n_o),
        .ram_we_n_o(ram_we_n_o), .uart_cs_n_o(uart_cs_n_o), .uart_rs_o(uart_rs_o),
        .uart_e_o(uart_e_o), .uart_rw_o(uart_rw_o), .sw_cs_n_o(sw_cs_n_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic sweep(input logic [7:0] a);
        for (int v = 0; v < 256; v++) begin
            logic io, top, rd, wr, dis, ewr, ecs, s1;
            logic exp_uart, exp_sw, exp_ram;
            {io, top, rd, wr, dis, ewr, ecs, s1} = v[7:0];
            io_m_i = io; a15_i = top; rd_n_i = rd; wr_n_i = wr;
            ram_rd_dis_i = dis; ext_wr_n_i = ewr; ext_cs_n_i = ecs; s1_i = s1;
            #1;
            exp_ram  = (io == 1'b0) && (top == 1'b0);
            exp_uart = io && (a[7] == 1'b0) && (a[4] == 1'b1);
            exp_sw   = (io && a[7]) || (ecs == 1'b0);
            check("R3 ram_oe_n", {7'd0, ram_oe_n_o}, {7'd0, !((rd == 1'b0) && (dis == 1'b0))});
            check("R4 ram_we_n", {7'd0, ram_we_n_o}, {7'd0, !((wr == 1'b0) || (ewr == 1'b0))});
            check("R5 ram_ce_n", {7'd0, ram_ce_n_o}, {7'd0, !exp_ram});
            check("R6 uart_cs_n", {7'd0, uart_cs_n_o}, {7'd0, !exp_uart});
            check("R6 uart_rs", {7'd0, uart_rs_o}, {7'd0, a[0]});
            check("R7 uart_e", {7'd0, uart_e_o}, {7'd0, (rd == 1'b0) || (wr == 1'b0)});
            check("R7 uart_rw", {7'd0, uart_rw_o}, {7'd0, s1});
            check("R8 sw_cs_n", {7'd0, sw_cs_n_o}, {7'd0, !exp_sw});
            if (ecs)
                check("R9 one select", 8'(int'(!ram_ce_n_o) + int'(!uart_cs_n_o) + int'(!sw_cs_n_o)) <= 8'd1 ? 8'd1 : 8'd0, 8'd1);
            if (rd && wr && ewr)
                check("R10 idle strobes", {5'd0, ram_oe_n_o, ram_we_n_o, uart_e_o}, 8'b0000_0110);
        end
        rd_n_i = 1'b1; wr_n_i = 1'b1; ext_wr_n_i = 1'b1; ext_cs_n_i = 1'b1;
        ram_rd_dis_i = 1'b0; io_m_i = 1'b0;
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R2 reset value", addr_lo_o, 8'h00);
        rst_n = 1'b1;
        for (int a = 0; a < 256; a++) begin
            @(negedge clk);
            ad_i = a[7:0];
            ale_i = 1'b1;
            #1;
            check("R1 transparent", addr_lo_o, a[7:0]);
            @(negedge clk);
            ale_i = 1'b0;
            ad_i = ~a[7:0];
            #1;
            check("R2 held after ALE", addr_lo_o, a[7:0]);
            sweep(a[7:0]);
            check("R2 hold over data phase", addr_lo_o, a[7:0]);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule